// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Bank

This block is a write-only serial slave that receives 8-bit configuration frames over three wires: a frame strobe, a serial clock and a data line. All three are brought into a faster system clock domain through two-flop synchronizers. Edges are then detected on the synchronized copies. While the strobe is low, every rising edge of the serial clock shifts one data bit in. The least significant bit arrives first. When the strobe rises, the top two bits of the frame select one of three 6-bit registers, and the low six bits are written into it.

The three registers hold mode and phase settings for six output channels, two channels per register. The block presents them as one flat vector and also as per-channel mode, phase-a and phase-b bits. Two inputs clear all stored settings and abandon any frame in progress. One is a power-save input that selects standby when low. The other is an undervoltage flag that acts when high.

A small state machine controls frame capture. Its states are IDLE (waiting for the strobe to fall), SHIFT (collecting bits) and COMMIT (a single cycle that writes the register). The transitions are: IDLE to SHIFT on a strobe falling edge, which also zeroes the shift register; SHIFT to COMMIT on a strobe rising edge; COMMIT to IDLE unconditionally; and any state to IDLE while a clear is active.

Top module: `serial_cfg_regs`

## Requirements
- R1: After reset, every bit of `cfg_flat` and of the per-channel outputs is 0.
- R2: Data is shifted only on serial clock rising edges while the strobe is low; serial clock edges while the strobe is high change no register.
- R3: Bits are taken least significant first: the first bit of an 8-bit frame becomes frame bit 0. Frame bits 7:6 are the address and bits 5:0 the data.
- R4: On the strobe rising edge the data field is written to the addressed register: address 0 to `cfg_flat[5:0]`, address 1 to `cfg_flat[11:6]`, address 2 to `cfg_flat[17:12]`. Other registers keep their values.
- R5: A frame with address 3 changes no register.
- R6: If more than 8 serial clocks arrive in one strobe-low window, the last 8 bits received form the frame.
- R7: The shift register is zeroed on the strobe falling edge. With n < 8 clocks, the first received bit lands at frame bit 8-n, lower bits are 0, and the result is committed. With no clocks at all, 0 is written to register 0.
- R8: While `pwr_on` is low, all registers read 0. A frame in progress when it falls is discarded, and a frame whose strobe falls while it is low is ignored.
- R9: While `uv_flag` is high, all registers read 0. A frame overlapping it is discarded in the same way as in R8.
- R10: For register k (channels 2k and 2k+1, counted from 0), bit 4 drives `ch_mode[2k]`, bit 5 drives `ch_mode[2k+1]`, bits 1/0 drive `ch_phase_a[2k]`/`ch_phase_b[2k]`, and bits 3/2 drive `ch_phase_a[2k+1]`/`ch_phase_b[2k+1]`.
- R11: `cfg_flat` changes only in the cycle after a commit or a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_strobe | input | 1 | Frame strobe; low while bits are shifted, rising edge commits |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, least significant bit first |
| pwr_on | input | 1 | Low selects standby and clears all settings |
| uv_flag | input | 1 | High indicates undervoltage and clears all settings |
| cfg_flat | output | 18 | Register 2, register 1, register 0 concatenated (register 0 lowest) |
| ch_mode | output | 6 | Mode bit per channel |
| ch_phase_a | output | 6 | Phase-a bit per channel |
| ch_phase_b | output | 6 | Phase-b bit per channel |

## Verification
The hardest case to reach from the ports is a clear that arrives in the middle of a strobe-low window. In that case the FSM must give up the frame, and it must not resume capture when the clear releases while the strobe is still low. The stimulus lowers the strobe, shifts three bits, drops `pwr_on` for several cycles and raises it again. It then shifts a complete, valid frame and raises the strobe, and the registers must still read zero. Short, empty and overlong windows are driven by varying the number of serial clocks per frame. The expected frame is built from the bits in the order they were sent.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } fsm_state_t;

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                sync_q <= RST_VAL[b];
                prev_q <= RST_VAL[b];
            end else begin
                meta_q <= async_in[b];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level[b] = sync_q;
        assign rise[b]  = sync_q & ~prev_q;
        assign fall[b]  = ~sync_q & prev_q;
    end

endmodule

// File: rtl/scfg_frame_fsm.sv
module scfg_frame_fsm
    import scfg_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               strobe_rise,
    input  logic               strobe_fall,
    input  logic               sclk_rise,
    input  logic               sdata,
    output logic               commit,
    output logic [FRAME_W-1:0] frame,
    output fsm_state_t         state_o
);

    fsm_state_t         state_q;
    fsm_state_t         state_d;
    logic [FRAME_W-1:0] shift_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (strobe_fall) state_d = ST_SHIFT;
                ST_SHIFT:  if (strobe_rise) state_d = ST_COMMIT;
                ST_COMMIT: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // shift register: zeroed on window open, LSB-first shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (clear) begin
            shift_q <= '0;
        end else if (state_q == ST_IDLE && strobe_fall) begin
            shift_q <= '0;
        end else if (state_q == ST_SHIFT && sclk_rise && !strobe_rise) begin
            shift_q <= {sdata, shift_q[FRAME_W-1:1]};
        end
    end

    // outputs
    always_comb begin
        commit  = (state_q == ST_COMMIT) && !clear;
        frame   = shift_q;
        state_o = state_q;
    end

endmodule

// File: rtl/scfg_reg_bank.sv
module scfg_reg_bank #(
    parameter int NUM_REGS = 3,
    parameter int REG_W    = 6,
    parameter int ADDR_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wdata,
    output logic [NUM_REGS*REG_W-1:0] flat,
    output logic [NUM_REGS-1:0]       wr_sel
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] val_q;

        assign wr_sel[g] = wr && (addr == ADDR_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (clear) begin
                val_q <= '0;
            end else if (wr_sel[g]) begin
                val_q <= wdata;
            end
        end

        assign flat[g*REG_W +: REG_W] = val_q;
    end

endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
    import scfg_pkg::*;
#(
    parameter int NUM_REGS = 3,
    parameter int REG_W    = 6,
    parameter int FRAME_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ser_strobe,
    input  logic                      ser_clk,
    input  logic                      ser_data,
    input  logic                      pwr_on,
    input  logic                      uv_flag,
    output logic [NUM_REGS*REG_W-1:0] cfg_flat,
    output logic [2*NUM_REGS-1:0]     ch_mode,
    output logic [2*NUM_REGS-1:0]     ch_phase_a,
    output logic [2*NUM_REGS-1:0]     ch_phase_b
);

    localparam int ADDR_W = FRAME_W - REG_W;
    localparam int LINE_STROBE = 0;
    localparam int LINE_SCLK   = 1;
    localparam int LINE_SDATA  = 2;

    logic [2:0]         lines_in;
    logic [2:0]         lines_lvl;
    logic [2:0]         lines_rise;
    logic [2:0]         lines_fall;
    logic               clear_w;
    logic               commit_w;
    logic [FRAME_W-1:0] frame_w;
    logic [ADDR_W-1:0]  frame_addr;
    logic [NUM_REGS-1:0] wr_sel_w;
    fsm_state_t         fsm_state;

    assign lines_in = {ser_data, ser_clk, ser_strobe};
    assign clear_w  = !pwr_on || uv_flag;

    scfg_sync #(
        .W       (3),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lines_in),
        .level    (lines_lvl),
        .rise     (lines_rise),
        .fall     (lines_fall)
    );

    scfg_frame_fsm #(
        .FRAME_W (FRAME_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear_w),
        .strobe_rise (lines_rise[LINE_STROBE]),
        .strobe_fall (lines_fall[LINE_STROBE]),
        .sclk_rise   (lines_rise[LINE_SCLK]),
        .sdata       (lines_lvl[LINE_SDATA]),
        .commit      (commit_w),
        .frame       (frame_w),
        .state_o     (fsm_state)
    );

    assign frame_addr = frame_w[FRAME_W-1:REG_W];

    scfg_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear_w),
        .wr     (commit_w),
        .addr   (frame_addr),
        .wdata  (frame_w[REG_W-1:0]),
        .flat   (cfg_flat),
        .wr_sel (wr_sel_w)
    );

    // per-channel split: register r serves channels 2r and 2r+1
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_chan
        assign ch_mode[2*r]      = cfg_flat[r*REG_W + 4];
        assign ch_mode[2*r+1]    = cfg_flat[r*REG_W + 5];
        assign ch_phase_a[2*r]   = cfg_flat[r*REG_W + 1];
        assign ch_phase_b[2*r]   = cfg_flat[r*REG_W + 0];
        assign ch_phase_a[2*r+1] = cfg_flat[r*REG_W + 3];
        assign ch_phase_b[2*r+1] = cfg_flat[r*REG_W + 2];
    end

endmodule

// File: rtl/scfg_chk.sv
module scfg_chk
    import scfg_pkg::*;
#(
    parameter int NUM_REGS = 3,
    parameter int REG_W    = 6,
    parameter int ADDR_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      pwr_on,
    input logic                      uv_flag,
    input logic                      commit,
    input logic [ADDR_W-1:0]         addr,
    input logic [NUM_REGS*REG_W-1:0] cfg_flat,
    input logic [NUM_REGS-1:0]       wr_sel,
    input fsm_state_t                state
);

    // R8
    standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (cfg_flat == '0));

    // R9
    undervolt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (cfg_flat == '0));

    // R5
    reserved_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == '1 && pwr_on && !uv_flag) |=> $stable(cfg_flat));

    // R11
    change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_flat) |-> ($past(commit) || !$past(pwr_on) || $past(uv_flag)));

    // R4
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R4
    commit_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (state == ST_IDLE));

endmodule

bind serial_cfg_regs scfg_chk #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .ADDR_W   (FRAME_W - REG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_on   (pwr_on),
    .uv_flag  (uv_flag),
    .commit   (commit_w),
    .addr     (frame_addr),
    .cfg_flat (cfg_flat),
    .wr_sel   (wr_sel_w),
    .state    (fsm_state)
);

// File: tb/tb_serial_cfg_regs.sv
module tb_serial_cfg_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_strobe = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        pwr_on = 1'b1;
    logic        uv_flag = 1'b0;
    logic [17:0] cfg_flat;
    logic [5:0]  ch_mode;
    logic [5:0]  ch_phase_a;
    logic [5:0]  ch_phase_b;

    int checks = 0;
    int fails  = 0;

    logic [5:0]  model [3];
    logic [17:0] exp_q [$];
    string       tag_q [$];
    event        chk_ev;

    always #10 clk = ~clk;

    serial_cfg_regs dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_strobe (ser_strobe),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .pwr_on     (pwr_on),
        .uv_flag    (uv_flag),
        .cfg_flat   (cfg_flat),
        .ch_mode    (ch_mode),
        .ch_phase_a (ch_phase_a),
        .ch_phase_b (ch_phase_b)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected register images and compares (R10 fields too)
    initial begin
        logic [17:0] e;
        logic [5:0]  em, ea, eb;
        string       t;
        forever begin
            @(chk_ev);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (cfg_flat !== e) begin
                fails++;
                $display("FAIL %s: cfg_flat actual %h expected %h", t, cfg_flat, e);
            end
            for (int r = 0; r < 3; r++) begin
                em[2*r]   = e[r*6+4]; em[2*r+1] = e[r*6+5];
                ea[2*r]   = e[r*6+1]; ea[2*r+1] = e[r*6+3];
                eb[2*r]   = e[r*6+0]; eb[2*r+1] = e[r*6+2];
            end
            checks++;
            if ({ch_mode, ch_phase_a, ch_phase_b} !== {em, ea, eb}) begin
                fails++;
                $display("FAIL R10 (%s): fields actual %h/%h/%h expected %h/%h/%h",
                         t, ch_mode, ch_phase_a, ch_phase_b, em, ea, eb);
            end
        end
    end

    task automatic expect_now(input string tag);
        exp_q.push_back({model[2], model[1], model[0]});
        tag_q.push_back(tag);
        -> chk_ev;
        @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = bits[i];
            ser_clk  = 1'b0;
            wait_cyc(4);
            ser_clk  = 1'b1;
            wait_cyc(4);
        end
        ser_clk = 1'b0;
        wait_cyc(4);
    endtask

    // drives a frame and updates the model from R3/R4/R5/R6/R7
    task automatic send_frame(input logic [15:0] bits, input int n, input bit live);
        logic [7:0] sh;
        sh = '0;
        ser_strobe = 1'b0;
        wait_cyc(4);
        shift_bits(bits, n);
        ser_strobe = 1'b1;
        wait_cyc(10);
        for (int i = 0; i < n; i++) sh = {bits[i], sh[7:1]};
        if (live && sh[7:6] != 2'b11) model[sh[7:6]] = sh[5:0];
    endtask

    initial begin
        model[0] = '0; model[1] = '0; model[2] = '0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(4);
        expect_now("R1 reset");

        send_frame(16'h0025, 8, 1'b1);               // addr 0, data 100101
        expect_now("R3/R4 addr0");
        send_frame(16'h005A, 8, 1'b1);               // addr 1, data 011010
        expect_now("R4 addr1");
        send_frame(16'h00B3, 8, 1'b1);               // addr 2, data 110011
        expect_now("R4 addr2");
        send_frame(16'h00FF, 8, 1'b1);               // addr 3 reserved
        expect_now("R5 reserved");

        // serial clocks with strobe high change nothing
        ser_strobe = 1'b1;
        shift_bits(16'hFFFF, 8);
        wait_cyc(8);
        expect_now("R2 strobe high");

        send_frame(16'h0103, 10, 1'b1);              // last 8 of 10 -> 0x40: addr1 data 0
        expect_now("R6 overlong");
        send_frame(16'h0036, 7, 1'b1);               // 7 bits -> addr1 data 101100
        expect_now("R7 short");
        send_frame(16'h0000, 0, 1'b1);               // empty window -> reg0 = 0
        expect_now("R7 empty");
        send_frame(16'h003F, 8, 1'b1);               // reg0 = 111111
        expect_now("R4 rewrite addr0");

        // standby mid-frame: clears and discards the frame in progress
        ser_strobe = 1'b0;
        wait_cyc(4);
        shift_bits(16'h0005, 3);
        pwr_on = 1'b0;
        wait_cyc(6);
        model[0] = '0; model[1] = '0; model[2] = '0;
        expect_now("R8 standby clear");
        pwr_on = 1'b1;
        wait_cyc(4);
        shift_bits(16'h0081, 8);
        ser_strobe = 1'b1;
        wait_cyc(10);
        expect_now("R8 aborted frame");

        send_frame(16'h0091, 8, 1'b1);               // addr 2, data 010001
        expect_now("R8 recovery");

        // undervoltage clears; a frame during it is ignored
        uv_flag = 1'b1;
        wait_cyc(4);
        model[0] = '0; model[1] = '0; model[2] = '0;
        expect_now("R9 uv clear");
        send_frame(16'h0015, 8, 1'b0);
        expect_now("R9 frame ignored");
        uv_flag = 1'b0;
        wait_cyc(4);
        send_frame(16'h006A, 8, 1'b1);               // addr 1, data 101010
        expect_now("R9 recovery");

        wait_cyc(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule